// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block takes over the job of retuning a PLL that would otherwise fall to a software routine. A one-cycle start pulse, together with a precomputed multiplier word, launches a fixed and safe order of register accesses on a simple internal register port. The block first reads the PLL control word. It writes that word back with the PLL powered down and every routing and enable bit stripped. It then loads the multiplier word and a divider word that sets both the pre-divider and the post-divider to one. Next it powers the PLL up.

After power-up the sequencer polls the lock flag. Each poll follows a programmable wait counted in system clock cycles, and the number of polls is bounded. On the first poll that sees lock, it sets the output clock enable and pulses `done_o`. If lock never arrives, it pulses `error_o` and leaves the output clock disabled. Computing the multiplier code, the analog PLL and the bus fabric all lie outside the block.

Top module: `pll_reprog_seq`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `busy_o`, `done_o`, `error_o`, `wr_en_o` and `rd_en_o` are all low.
- R2: After an accepted start, the first access reads the control register. The next access writes the control register with the value read, bit 0 (power-down) set, bits 1 to 4 (bypass, direct-in, direct-out, clock enable) cleared, and all other bits unchanged.
- R3: While powered down, the block writes the latched multiplier word to the multiplier register and then writes 0x00302062 to the divider register, in that order.
- R4: The fourth write goes to the control register with bit 0 cleared, bits 1 to 4 still cleared and the other bits unchanged.
- R5: Each status read is issued WAIT_CYCLES+1 cycles after the power-up write, or WAIT_CYCLES+2 cycles after the previous status read.
- R6: On the first status read whose bit 0 is 1, the block issues no further status reads. It makes a fifth write to the control register equal to the power-up value with bit 4 set, then pulses `done_o` for one cycle.
- R7: The block issues at most MAX_TRIES status reads. If none of them shows lock, it pulses `error_o` for one cycle after exactly four writes, and bit 4 of the control register stays clear.
- R8: `busy_o` is high from the cycle after an accepted start until the cycle in which `done_o` or `error_o` pulses, and it is low in that cycle. Exactly one of the two pulses occurs per run.
- R9: A start pulse while `busy_o` is high is ignored. The run writes the multiplier word latched at the accepted start, and no second sequence follows.
- R10: Only bit 0 of the status word decides lock. A status word with every other bit set and bit 0 clear counts as not locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a reprogramming run |
| mult_i | input | DATA_W | Multiplier word, latched at an accepted start |
| wr_en_o | output | 1 | Single-cycle register write strobe |
| wr_addr_o | output | ADDR_W | Write address |
| wr_data_o | output | DATA_W | Write data |
| rd_en_o | output | 1 | Register read strobe |
| rd_addr_o | output | ADDR_W | Read address |
| rd_data_i | input | DATA_W | Read data, valid the cycle after `rd_en_o` |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse: locked, output enabled |
| error_o | output | 1 | One-cycle pulse: lock not seen in the allowed polls |

## Verification
The bench builds the block with WAIT_CYCLES set to 6 instead of the microsecond-scale default, and MAX_TRIES is left at 4. With these values a run that uses all four polls finishes in a few dozen cycles, so the lock-on-first-poll case, the lock-on-last-poll case and the never-lock case can all be run back to back. The short wait also makes the spacing between the power-up write and each status read small enough to measure exactly.

// File: rtl/pll_seq_pkg.sv
// Package pll_seq_pkg
// Holds the shared definitions of the PLL reprogramming sequencer: the bit
// positions in the control and status words, and the sequencer state type.
// Assumes the control word layout is fixed by the PLL it drives.
package pll_seq_pkg;

    localparam int CB_PD    = 0;  // power-down
    localparam int CB_BYP   = 1;  // bypass
    localparam int CB_DIN   = 2;  // direct input
    localparam int CB_DOUT  = 3;  // direct output
    localparam int CB_CLKEN = 4;  // output clock enable
    localparam int ST_LOCK  = 0;  // lock flag in status word

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_CTRL,
        S_WR_PD,
        S_WR_MULT,
        S_WR_DIV,
        S_WR_PU,
        S_WAIT,
        S_RD_STAT,
        S_CHK,
        S_WR_EN
    } seq_state_e;

endpackage

// File: rtl/seq_wait_timer.sv
// Module seq_wait_timer
// One-shot interval timer. A load pulse starts a countdown of WAIT_CYCLES
// cycles, and expired_o is high in the last of them. Assumes WAIT_CYCLES >= 1
// and that the timer is never reloaded while it is running.
module seq_wait_timer #(
    parameter int WAIT_CYCLES = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(WAIT_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    // Countdown register: load, decrement, stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load_i) begin
            cnt_q <= CNT_W'(WAIT_CYCLES - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = run_q && (cnt_q == '0);

    // R5
    timer_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !run_q);

    // R5
    timer_single_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expired_o |=> !expired_o);

endmodule

// File: rtl/seq_try_counter.sv
// Module seq_try_counter
// Counts lock polls in one run. last_o is high while the current poll is the
// final one allowed. Assumes MAX_TRIES >= 1 and that the controller clears
// the counter at each accepted start.
module seq_try_counter #(
    parameter int MAX_TRIES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int CNT_W = $clog2(MAX_TRIES + 1);

    logic [CNT_W-1:0] cnt_q;

    // Poll index register: cleared per run, bumped per failed poll.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear_i) cnt_q <= '0;
        else if (inc_i)   cnt_q <= cnt_q + 1'b1;
    end

    assign last_o = (cnt_q == CNT_W'(MAX_TRIES - 1));

    // R7
    try_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |-> !last_o);

endmodule

// File: rtl/seq_ctrl_fsm.sv
// Module seq_ctrl_fsm
// Main controller of the sequencer. Walks the fixed safe update order
// (read control, power down and strip, multiplier, dividers, power up, timed
// lock polls, enable) and drives the register port from its state. Assumes
// read data returns one cycle after rd_en_o.
module seq_ctrl_fsm
    import pll_seq_pkg::*;
#(
    parameter int                DATA_W     = 32,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h00,
    parameter logic [ADDR_W-1:0] STAT_ADDR  = 8'h04,
    parameter logic [ADDR_W-1:0] MULT_ADDR  = 8'h08,
    parameter logic [ADDR_W-1:0] DIV_ADDR   = 8'h0C,
    parameter logic [DATA_W-1:0] DIV_UNITY  = 32'h0030_2062
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] mult_i,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic              timer_exp_i,
    input  logic              try_last_i,
    output logic              timer_load_o,
    output logic              try_clear_o,
    output logic              try_inc_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              error_o
);
    localparam logic [DATA_W-1:0] PD_M    = DATA_W'(1) << CB_PD;
    localparam logic [DATA_W-1:0] EN_M    = DATA_W'(1) << CB_CLKEN;
    localparam logic [DATA_W-1:0] STRIP_M = (DATA_W'(1) << CB_BYP) | (DATA_W'(1) << CB_DIN)
                                          | (DATA_W'(1) << CB_DOUT) | EN_M;

    seq_state_e        state_q, state_d;
    logic [DATA_W-1:0] shadow_q;
    logic [DATA_W-1:0] mult_q;
    logic [DATA_W-1:0] pd_val;
    logic              done_q, err_q;
    logic              locked;
    logic              retry;

    assign pd_val = (rd_data_i | PD_M) & ~STRIP_M;
    assign locked = rd_data_i[ST_LOCK];
    assign retry  = (state_q == S_CHK) && !locked && !try_last_i;

    // Next-state selection along the fixed update order.
    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE:    if (start_i) state_d = S_RD_CTRL;
            S_RD_CTRL: state_d = S_WR_PD;
            S_WR_PD:   state_d = S_WR_MULT;
            S_WR_MULT: state_d = S_WR_DIV;
            S_WR_DIV:  state_d = S_WR_PU;
            S_WR_PU:   state_d = S_WAIT;
            S_WAIT:    if (timer_exp_i) state_d = S_RD_STAT;
            S_RD_STAT: state_d = S_CHK;
            S_CHK:     state_d = locked ? S_WR_EN : (try_last_i ? S_IDLE : S_WAIT);
            S_WR_EN:   state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // State, captured words and outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            shadow_q <= '0;
            mult_q   <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == S_WR_EN);
            err_q   <= (state_q == S_CHK) && !locked && try_last_i;
            if (state_q == S_IDLE && start_i) mult_q   <= mult_i;
            if (state_q == S_WR_PD)           shadow_q <= pd_val;
        end
    end

    // Register port drive decoded from the current state.
    always_comb begin
        wr_en_o   = 1'b0;
        wr_addr_o = CTRL_ADDR;
        wr_data_o = '0;
        rd_en_o   = 1'b0;
        rd_addr_o = CTRL_ADDR;
        case (state_q)
            S_RD_CTRL: rd_en_o = 1'b1;
            S_WR_PD:   begin wr_en_o = 1'b1; wr_data_o = pd_val; end
            S_WR_MULT: begin wr_en_o = 1'b1; wr_addr_o = MULT_ADDR; wr_data_o = mult_q; end
            S_WR_DIV:  begin wr_en_o = 1'b1; wr_addr_o = DIV_ADDR;  wr_data_o = DIV_UNITY; end
            S_WR_PU:   begin wr_en_o = 1'b1; wr_data_o = shadow_q & ~PD_M; end
            S_RD_STAT: begin rd_en_o = 1'b1; rd_addr_o = STAT_ADDR; end
            S_WR_EN:   begin wr_en_o = 1'b1; wr_data_o = (shadow_q & ~PD_M) | EN_M; end
            default:   ;
        endcase
    end

    assign timer_load_o = (state_q == S_WR_PU) || retry;
    assign try_clear_o  = (state_q == S_IDLE) && start_i;
    assign try_inc_o    = retry;
    assign busy_o       = (state_q != S_IDLE);
    assign done_o       = done_q;
    assign error_o      = err_q;

    // R2
    pd_write_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_addr_o == CTRL_ADDR && wr_data_o[CB_PD]) |-> (wr_data_o[CB_CLKEN:CB_BYP] == '0));

    // R6
    enable_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_addr_o == CTRL_ADDR && wr_data_o[CB_CLKEN]) |-> ($past(rd_data_i[ST_LOCK]) && !wr_data_o[CB_PD]));

    // R8
    outcome_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || error_o) |-> !busy_o);

    // R8
    outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && error_o));

    // R9
    mult_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && state_q != S_WR_EN) |=> $stable(mult_q));

endmodule

// File: rtl/pll_reprog_seq.sv
// Module pll_reprog_seq
// Top of the PLL reprogramming sequencer: joins the controller, the poll
// interval timer and the poll counter. Assumes a register port whose read data
// is registered (one cycle latency) and whose writes take effect in one cycle.
module pll_reprog_seq #(
    parameter int                DATA_W      = 32,
    parameter int                ADDR_W      = 8,
    parameter int                WAIT_CYCLES = 1250,
    parameter int                MAX_TRIES   = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'h00,
    parameter logic [ADDR_W-1:0] STAT_ADDR   = 8'h04,
    parameter logic [ADDR_W-1:0] MULT_ADDR   = 8'h08,
    parameter logic [ADDR_W-1:0] DIV_ADDR    = 8'h0C,
    parameter logic [DATA_W-1:0] DIV_UNITY   = 32'h0030_2062
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] mult_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              error_o
);
    logic timer_load, timer_exp;
    logic try_clear, try_inc, try_last;

    seq_ctrl_fsm #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR),
        .MULT_ADDR(MULT_ADDR), .DIV_ADDR(DIV_ADDR), .DIV_UNITY(DIV_UNITY)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mult_i(mult_i),
        .rd_data_i(rd_data_i), .timer_exp_i(timer_exp), .try_last_i(try_last),
        .timer_load_o(timer_load), .try_clear_o(try_clear), .try_inc_o(try_inc),
        .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
        .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
    );

    seq_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(timer_load), .expired_o(timer_exp)
    );

    seq_try_counter #(.MAX_TRIES(MAX_TRIES)) u_tries (
        .clk(clk), .rst_n(rst_n), .clear_i(try_clear), .inc_i(try_inc), .last_o(try_last)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> !(busy_o || done_o || error_o || wr_en_o || rd_en_o));

    // R6
    no_poll_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_addr_o == CTRL_ADDR && wr_data_o[pll_seq_pkg::CB_CLKEN]) |-> !rd_en_o);

endmodule

// File: tb/test_pll_reprog_seq.sv
module test_pll_reprog_seq;
    localparam int          W      = 6;
    localparam int          TRIES  = 4;
    localparam logic [7:0]  A_CTRL = 8'h00;
    localparam logic [7:0]  A_STAT = 8'h04;
    localparam logic [7:0]  A_MULT = 8'h08;
    localparam logic [7:0]  A_DIV  = 8'h0C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] mult = '0;
    logic        wr_en, rd_en, busy, done, error;
    logic [7:0]  wr_addr, rd_addr;
    logic [31:0] wr_data;
    logic [31:0] rd_data = '0;

    int n_chk = 0;
    int n_bad = 0;

    // register model state
    logic        clr_req = 1'b0;
    logic [31:0] ctrl_init = '0;
    logic [31:0] stat_fill = '0;
    int          lock_at = 0;
    logic [31:0] ctrl_reg = '0;
    int          cyc = 0;
    int          wr_n = 0, st_n = 0, done_n = 0, err_n = 0, overlap_n = 0;
    logic [7:0]  lg_a [0:15];
    logic [31:0] lg_d [0:15];
    int          lg_c [0:15];
    int          st_c [0:7];

    always #4 clk = ~clk;

    pll_reprog_seq #(.WAIT_CYCLES(W), .MAX_TRIES(TRIES)) i_pll_reprog_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mult_i(mult),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .busy_o(busy), .done_o(done), .error_o(error)
    );

    // Register file model with registered read and an access log.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (clr_req) begin
            wr_n <= 0; st_n <= 0; done_n <= 0; err_n <= 0; overlap_n <= 0;
            ctrl_reg <= ctrl_init;
        end else begin
            if (rd_en) begin
                if (rd_addr == A_STAT) begin
                    rd_data <= stat_fill | {31'b0, (lock_at != 0 && st_n + 1 >= lock_at)};
                    if (st_n < 8) st_c[st_n] <= cyc;
                    st_n <= st_n + 1;
                end else begin
                    rd_data <= ctrl_reg;
                end
            end
            if (wr_en) begin
                if (wr_n < 16) begin
                    lg_a[wr_n] <= wr_addr; lg_d[wr_n] <= wr_data; lg_c[wr_n] <= cyc;
                end
                wr_n <= wr_n + 1;
                if (wr_addr == A_CTRL) ctrl_reg <= wr_data;
            end
            if (done)  done_n <= done_n + 1;
            if (error) err_n  <= err_n + 1;
            if ((done || error) && busy) overlap_n <= overlap_n + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one sequence; optional second start while busy.
    task automatic run_seq(input logic [31:0] init, input logic [31:0] m, input int lk,
                           input logic [31:0] fill, input bit poke);
        int guard;
        ctrl_init = init; stat_fill = fill; lock_at = lk;
        @(negedge clk) clr_req = 1'b1;
        @(negedge clk) clr_req = 1'b0;
        start = 1'b1; mult = m;
        @(negedge clk) start = 1'b0;
        chk("R8 busy after start", 32'(busy), 32'd1);
        if (poke) begin
            @(negedge clk) start = 1'b1; mult = ~m;
            @(negedge clk) start = 1'b0;
        end
        guard = 0;
        while (done_n + err_n == 0 && guard < 500) begin
            @(negedge clk); guard++;
        end
        if (guard >= 500) chk("R8 run ended", 32'd0, 32'd1);
        repeat (W + 8) @(negedge clk);
    endtask

    function automatic logic [31:0] pd_of(input logic [31:0] v);
        return (v | 32'h1) & ~32'h1E;
    endfunction

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", 32'(busy), 0);
        chk("R1 strobes in reset", 32'({wr_en, rd_en, done, error}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 quiet after reset", 32'({busy, wr_en, rd_en, done, error}), 0);
    endtask

    task automatic t_first_lock;
        logic [31:0] init = 32'h0A00_001F;
        run_seq(init, 32'h0001_8003, 1, 32'h0, 1'b0);
        chk("R6 write count", 32'(wr_n), 5);
        chk("R2 pd addr", 32'(lg_a[0]), 32'(A_CTRL));
        chk("R2 pd data", lg_d[0], pd_of(init));
        chk("R3 mult addr", 32'(lg_a[1]), 32'(A_MULT));
        chk("R3 mult data", lg_d[1], 32'h0001_8003);
        chk("R3 div addr", 32'(lg_a[2]), 32'(A_DIV));
        chk("R3 div data", lg_d[2], 32'h0030_2062);
        chk("R4 pu data", lg_d[3], pd_of(init) & ~32'h1);
        chk("R6 enable data", lg_d[4], (pd_of(init) & ~32'h1) | 32'h10);
        chk("R6 single poll", 32'(st_n), 1);
        chk("R5 first poll spacing", 32'(st_c[0] - lg_c[3]), 32'(W + 1));
        chk("R8 done once", 32'(done_n), 1);
        chk("R8 no error", 32'(err_n), 0);
        chk("R8 busy low at outcome", 32'(overlap_n), 0);
    endtask

    task automatic t_last_lock;
        logic [31:0] init = 32'h0000_0004;
        run_seq(init, 32'h0000_4321, TRIES, 32'h0, 1'b0);
        chk("R7 polls at limit", 32'(st_n), 32'(TRIES));
        chk("R6 done on last poll", 32'(done_n), 1);
        chk("R6 enable addr", 32'(lg_a[4]), 32'(A_CTRL));
        chk("R6 enable data", lg_d[4], 32'h0000_0010);
        chk("R5 poll spacing 1", 32'(st_c[1] - st_c[0]), 32'(W + 2));
        chk("R5 poll spacing 3", 32'(st_c[3] - st_c[2]), 32'(W + 2));
    endtask

    task automatic t_no_lock;
        logic [31:0] init = 32'h5500_0012;
        run_seq(init, 32'h0000_1111, 0, 32'h0, 1'b0);
        chk("R7 polls bounded", 32'(st_n), 32'(TRIES));
        chk("R7 error once", 32'(err_n), 1);
        chk("R7 no done", 32'(done_n), 0);
        chk("R7 four writes", 32'(wr_n), 4);
        chk("R7 clock enable clear", 32'(ctrl_reg[4]), 0);
        chk("R8 busy low at error", 32'(overlap_n), 0);
    endtask

    task automatic t_other_bits;
        run_seq(32'h0, 32'h0000_0077, 0, 32'hFFFF_FFFE, 1'b0);
        chk("R10 upper bits not lock", 32'(err_n), 1);
        chk("R10 polls used", 32'(st_n), 32'(TRIES));
        run_seq(32'h0, 32'h0000_0077, 2, 32'hFFFF_FFFE, 1'b0);
        chk("R10 bit0 decides", 32'(done_n), 1);
        chk("R10 polls to lock", 32'(st_n), 2);
    endtask

    task automatic t_busy_start;
        run_seq(32'h0100_0000, 32'h0000_ABCD, 1, 32'h0, 1'b1);
        chk("R9 mult from first start", lg_d[1], 32'h0000_ABCD);
        chk("R9 single sequence", 32'(wr_n), 5);
        chk("R9 single outcome", 32'(done_n + err_n), 1);
        chk("R9 idle after run", 32'(busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_first_lock();
        t_last_lock();
        t_no_lock();
        t_other_bits();
        t_busy_start();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule